// File: doc/BRIEF.md
# Chained Four-Channel Byte DMA Engine

This block moves bytes between buffers in a shared memory on behalf of four independent channels. Each channel has a source base address, a destination base address and three sizes in bytes: source, destination and cell. A channel watches one of several trigger lines that it selects itself. Each start event it accepts moves one cell of bytes. The source and destination pointers advance on their own and each wraps to zero at its own size. A block is the larger of the two sizes. When a channel completes a block, a sticky done flag is set, and the channel can hand over to a neighbouring channel by enabling it.

All channels share one copy engine. The engine reads a byte in one cycle and writes it in the next, through a synchronous single-port byte memory. Between cells, an arbiter picks the pending channel with the highest priority. A start event that arrives while a channel is disabled is either dropped or held until the channel is enabled, as set per channel. This makes ping-pong and hand-over schemes possible without software stepping in.

Top module: `dmac_top`

## Requirements
- R1: After reset all done flags and enables read 0, `busy` is 0 and no memory write is issued.
- R2: One accepted start event moves exactly one cell. For each byte the engine drives the source address with `mem_we`=0 in one cycle, then the destination address with `mem_we`=1 in the next cycle, writing the byte read.
- R3: The source and destination pointers each wrap to offset 0 at their own size. A block is max(source size, destination size) bytes. A cell that would run past the end of the block stops there, and both pointers return to 0.
- R4: On block completion the channel's done flag is set and its enable is cleared, unless control bit 4 (auto-enable) is set, in which case it stays enabled.
- R5: A done flag stays set until a write to field 6 (clear-done) for that channel. That write starts no transfer.
- R6: Several channels that select the same trigger line each transfer a cell for one event on it.
- R7: When several channels are pending, the one with the higher priority (control bits 6:5, 3 highest) moves its cell first. Among equal priorities the lower channel number goes first.
- R8: A start event seen while a channel is disabled is dropped when control bit 3 is 0. When bit 3 is 1 the event is held, and the cell transfer begins once the channel is enabled.
- R9: With control bit 1 (chain) set, a channel's enable is set in the same cycle that its partner completes a block. The partner is channel n-1 when control bit 2 is 0 and channel n+1 when it is 1.
- R10: Further start events for a channel that already has a cell pending merge into the one pending request and do not produce extra cells.
- R11: A config write selects the channel with `cfg_chan` and the field with `cfg_field`: 0 control (bit 0 enable, bits 9:8 trigger select), 1 source base, 2 destination base, 3 source size, 4 destination size, 5 cell size, 6 clear-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_field | input | 3 | Field addressed by the write |
| cfg_wdata | input | 16 | Write data |
| trig | input | 4 | Start-event lines, one event per high cycle |
| mem_addr | output | 8 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after its address |
| done | output | 4 | Per-channel sticky block-complete flags |
| chan_en | output | 4 | Per-channel enable state |
| busy | output | 1 | Engine is inside a cell |

## Verification
Single-channel runs with a cell smaller than the block show that one event moves exactly one cell and that done appears only at block end. Unequal source and destination sizes with an oversized cell separate independent pointer wrapping and block truncation from a common counter. One trigger shared by four channels with mixed priorities gives a single legal service order, so ordering errors and tie-break errors both show up. Disabled-channel events with the hold bit clear and set, chain hand-over in both directions, and repeated triggers during another channel's cell separate dropping, latching, partner selection and merging.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [2:0] F_CTRL = 3'd0;
  localparam logic [2:0] F_SRCB = 3'd1;
  localparam logic [2:0] F_DSTB = 3'd2;
  localparam logic [2:0] F_SSZ  = 3'd3;
  localparam logic [2:0] F_DSZ  = 3'd4;
  localparam logic [2:0] F_CSZ  = 3'd5;
  localparam logic [2:0] F_CLR  = 3'd6;

  typedef enum logic [1:0] {E_IDLE = 2'd0, E_RD = 2'd1, E_WR = 2'd2} eng_e;
endpackage

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0]   req_i,
  input  logic [2*NCH-1:0] prio_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  logic [1:0] best_p;

  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    best_p = 2'd0;
    for (int ch = NCH - 1; ch >= 0; ch--) begin
      if (req_i[ch] && (!any_o || prio_i[2*ch +: 2] >= best_p)) begin
        any_o  = 1'b1;
        idx_o  = IW'(ch);
        best_p = prio_i[2*ch +: 2];
      end
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_field_i,
  input  logic [15:0]      cfg_wdata_i,
  input  logic [NTRIG-1:0] trig_i,
  input  logic             blk_done_lo_i,
  input  logic             blk_done_hi_i,
  input  logic             grant_i,
  input  logic             step_i,
  output logic             req_o,
  output logic [1:0]       prio_o,
  output logic [AW-1:0]    src_addr_o,
  output logic [AW-1:0]    dst_addr_o,
  output logic [AW-1:0]    csz_o,
  output logic             last_o,
  output logic             blk_done_o,
  output logic             en_o,
  output logic             done_o
);
  localparam int TSW = (NTRIG > 1) ? $clog2(NTRIG) : 1;

  logic           en_q, en_d, chain_q, chain_d, dir_q, dir_d;
  logic           acc_q, acc_d, auto_q, auto_d, pend_q, pend_d, done_q, done_d;
  logic [1:0]     prio_q, prio_d;
  logic [TSW-1:0] sel_q, sel_d;
  logic [AW-1:0]  sb_q, sb_d, db_q, db_d, ss_q, ss_d, ds_q, ds_d, cs_q, cs_d;
  logic [AW-1:0]  sp_q, sp_d, dp_q, dp_d, bp_q, bp_d, blk_max;
  logic           ev, chain_hit;

  assign ev         = trig_i[sel_q];
  assign blk_max    = (ss_q > ds_q) ? ss_q : ds_q;
  assign last_o     = (bp_q == blk_max - 1'b1);
  assign blk_done_o = step_i & last_o;
  assign chain_hit  = chain_q & (dir_q ? blk_done_hi_i : blk_done_lo_i);
  assign req_o      = pend_q & en_q;
  assign prio_o     = prio_q;
  assign src_addr_o = sb_q + sp_q;
  assign dst_addr_o = db_q + dp_q;
  assign csz_o      = cs_q;
  assign en_o       = en_q;
  assign done_o     = done_q;

  always_comb begin
    en_d = en_q; chain_d = chain_q; dir_d = dir_q; acc_d = acc_q; auto_d = auto_q;
    prio_d = prio_q; sel_d = sel_q; done_d = done_q;
    sb_d = sb_q; db_d = db_q; ss_d = ss_q; ds_d = ds_q; cs_d = cs_q;
    sp_d = sp_q; dp_d = dp_q; bp_d = bp_q;
    pend_d = (pend_q & ~grant_i) | (ev & (en_q | acc_q));
    if (step_i) begin
      if (last_o) begin
        sp_d = '0; dp_d = '0; bp_d = '0;
        done_d = 1'b1;
        if (!auto_q) en_d = 1'b0;
      end else begin
        sp_d = (sp_q == ss_q - 1'b1) ? '0 : sp_q + 1'b1;
        dp_d = (dp_q == ds_q - 1'b1) ? '0 : dp_q + 1'b1;
        bp_d = bp_q + 1'b1;
      end
    end
    if (chain_hit) en_d = 1'b1;
    if (cfg_we_i) begin
      case (cfg_field_i)
        F_CTRL: begin
          en_d = cfg_wdata_i[0]; chain_d = cfg_wdata_i[1]; dir_d = cfg_wdata_i[2];
          acc_d = cfg_wdata_i[3]; auto_d = cfg_wdata_i[4];
          prio_d = cfg_wdata_i[6:5]; sel_d = cfg_wdata_i[8 +: TSW];
        end
        F_SRCB:  sb_d = cfg_wdata_i[AW-1:0];
        F_DSTB:  db_d = cfg_wdata_i[AW-1:0];
        F_SSZ:   ss_d = cfg_wdata_i[AW-1:0];
        F_DSZ:   ds_d = cfg_wdata_i[AW-1:0];
        F_CSZ:   cs_d = cfg_wdata_i[AW-1:0];
        F_CLR:   done_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; chain_q <= 1'b0; dir_q <= 1'b0; acc_q <= 1'b0; auto_q <= 1'b0;
      pend_q <= 1'b0; done_q <= 1'b0; prio_q <= '0; sel_q <= '0;
      sb_q <= '0; db_q <= '0; ss_q <= '0; ds_q <= '0; cs_q <= '0;
      sp_q <= '0; dp_q <= '0; bp_q <= '0;
    end else begin
      en_q <= en_d; chain_q <= chain_d; dir_q <= dir_d; acc_q <= acc_d; auto_q <= auto_d;
      pend_q <= pend_d; done_q <= done_d; prio_q <= prio_d; sel_q <= sel_d;
      sb_q <= sb_d; db_q <= db_d; ss_q <= ss_d; ds_q <= ds_d; cs_q <= cs_d;
      sp_q <= sp_d; dp_q <= dp_d; bp_q <= bp_d;
    end
  end

  p_wrap_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && last_o |=> sp_q == '0 && dp_q == '0);
  p_block_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_o && !auto_q && !chain_hit && !cfg_we_i |=> !en_q && done_q);
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !(cfg_we_i && cfg_field_i == F_CLR) |=> done_q);
  p_grant_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> req_o);
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !acc_q && !pend_q && !cfg_we_i |=> !pend_q);
  p_chain_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_hit && !cfg_we_i |=> en_q);
  p_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !grant_i |=> pend_q);
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NTRIG = 4,
  parameter int AW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_chan,
  input  logic [2:0]             cfg_field,
  input  logic [15:0]            cfg_wdata,
  input  logic [NTRIG-1:0]       trig,
  output logic [AW-1:0]          mem_addr,
  output logic                   mem_we,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic [NCH-1:0]         done,
  output logic [NCH-1:0]         chan_en,
  output logic                   busy
);
  localparam int IW = $clog2(NCH);

  eng_e            state_q, state_d;
  logic [IW-1:0]   act_q, act_d, win_idx;
  logic [AW-1:0]   cnt_q, cnt_d;
  logic            win_any;
  logic [NCH-1:0]  req_w, grant_w, step_w, last_w, blkd_w, lo_w, hi_w;
  logic [2*NCH-1:0] prio_w;
  logic [AW-1:0]   src_a [NCH];
  logic [AW-1:0]   dst_a [NCH];
  logic [AW-1:0]   csz_a [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_lo0
      assign lo_w[i] = 1'b0;
    end else begin : g_lo
      assign lo_w[i] = blkd_w[i-1];
    end
    if (i == NCH - 1) begin : g_hiN
      assign hi_w[i] = 1'b0;
    end else begin : g_hi
      assign hi_w[i] = blkd_w[i+1];
    end
    assign grant_w[i] = (state_q == E_IDLE) && win_any && (win_idx == IW'(i));
    assign step_w[i]  = (state_q == E_WR) && (act_q == IW'(i));

    dmac_chan #(.AW(AW), .NTRIG(NTRIG)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .cfg_we_i(cfg_we && cfg_chan == IW'(i)), .cfg_field_i(cfg_field),
      .cfg_wdata_i(cfg_wdata), .trig_i(trig),
      .blk_done_lo_i(lo_w[i]), .blk_done_hi_i(hi_w[i]),
      .grant_i(grant_w[i]), .step_i(step_w[i]),
      .req_o(req_w[i]), .prio_o(prio_w[2*i +: 2]),
      .src_addr_o(src_a[i]), .dst_addr_o(dst_a[i]), .csz_o(csz_a[i]),
      .last_o(last_w[i]), .blk_done_o(blkd_w[i]),
      .en_o(chan_en[i]), .done_o(done[i])
    );
  end

  dmac_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .req_i(req_w), .prio_i(prio_w), .any_o(win_any), .idx_o(win_idx)
  );

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    cnt_d   = cnt_q;
    case (state_q)
      E_IDLE: if (win_any) begin
        act_d = win_idx; cnt_d = '0; state_d = E_RD;
      end
      E_RD: state_d = E_WR;
      E_WR: begin
        if (cnt_q == csz_a[act_q] - 1'b1 || last_w[act_q]) begin
          state_d = E_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1; state_d = E_RD;
        end
      end
      default: state_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= E_IDLE; act_q <= '0; cnt_q <= '0;
    end else begin
      state_q <= state_d; act_q <= act_d; cnt_q <= cnt_d;
    end
  end

  always_comb begin
    case (state_q)
      E_RD:    mem_addr = src_a[act_q];
      E_WR:    mem_addr = dst_a[act_q];
      default: mem_addr = '0;
    endcase
  end
  assign mem_we    = (state_q == E_WR);
  assign mem_wdata = mem_rdata;
  assign busy      = (state_q != E_IDLE);

  p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == E_RD |=> mem_we);
  p_no_back2back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_w));
endmodule

// File: tb/dmac_top_test.sv
`timescale 1ns/1ps
module dmac_top_test;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_chan;
  logic [2:0] cfg_field;
  logic [15:0] cfg_wdata;
  logic [3:0] trig;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we, busy;
  logic [3:0] done, chan_en;

  int checks = 0;
  int failures = 0;
  int expq[$];
  logic [7:0] mem [256];

  int m_sb[4], m_db[4], m_ss[4], m_ds[4], m_cs[4], m_sp[4], m_dp[4], m_bp[4];

  always #2.5 clk = ~clk;

  dmac_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .trig(trig),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .chan_en(chan_en), .busy(busy)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 8'(i ^ 8'hA5) : 8'h00;

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  // Reference comparison every clock: each write must match the model's next byte.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected write addr=%02h data=%02h expected none", mem_addr, mem_wdata);
      end else begin
        int e;
        e = expq.pop_front();
        if ({mem_addr, mem_wdata} !== 16'(e)) begin
          failures++;
          $display("FAIL R2/R3 write actual=%04h expected=%04h", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_chan = '0; cfg_field = '0; cfg_wdata = '0; trig = '0;
    expq.delete();
    for (int c = 0; c < 4; c++) begin
      m_sb[c] = 0; m_db[c] = 0; m_ss[c] = 0; m_ds[c] = 0; m_cs[c] = 0;
      m_sp[c] = 0; m_dp[c] = 0; m_bp[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int ch, input int f, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_field = 3'(f); cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    case (f)
      1: m_sb[ch] = v;
      2: m_db[ch] = v;
      3: m_ss[ch] = v;
      4: m_ds[ch] = v;
      5: m_cs[ch] = v;
      default: ;
    endcase
  endtask

  function automatic int ctrl(int en, int chn, int dir, int acc, int aut, int pr, int sel);
    return en | (chn << 1) | (dir << 2) | (acc << 3) | (aut << 4) | (pr << 5) | (sel << 8);
  endfunction

  task automatic setup(input int ch, input int sb, input int db, input int ss, input int ds, input int cs);
    cfg(ch, 1, sb); cfg(ch, 2, db); cfg(ch, 3, ss); cfg(ch, 4, ds); cfg(ch, 5, cs);
  endtask

  // Behavioural model of one cell: independent wraps, truncation at block end.
  task automatic m_cell(input int ch);
    int blk;
    blk = (m_ss[ch] > m_ds[ch]) ? m_ss[ch] : m_ds[ch];
    for (int k = 0; k < m_cs[ch]; k++) begin
      int sa, da;
      sa = (m_sb[ch] + m_sp[ch]) & 255;
      da = (m_db[ch] + m_dp[ch]) & 255;
      expq.push_back((da << 8) | (sa ^ 8'hA5));
      m_bp[ch]++;
      if (m_bp[ch] == blk) begin
        m_sp[ch] = 0; m_dp[ch] = 0; m_bp[ch] = 0;
        break;
      end
      m_sp[ch] = (m_sp[ch] + 1 == m_ss[ch]) ? 0 : m_sp[ch] + 1;
      m_dp[ch] = (m_dp[ch] + 1 == m_ds[ch]) ? 0 : m_dp[ch] + 1;
    end
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); trig = m;
    @(negedge clk); trig = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk(done == 0, "R1 done", done, 0);
    chk(chan_en == 0, "R1 chan_en", chan_en, 0);
    chk(!busy && !mem_we, "R1 busy/we", {busy, mem_we}, 0);

    // R2 R4 R11 one cell per event, done at block end
    setup(0, 8'h20, 8'h80, 4, 4, 2);
    cfg(0, 0, ctrl(1, 0, 0, 0, 0, 0, 0));
    m_cell(0); pulse(4'b0001); settle(20);
    chk(expq.size() == 0, "R2 first cell", expq.size(), 0);
    chk(done[0] == 0, "R2 done mid-block", done, 0);
    m_cell(0); pulse(4'b0001); settle(20);
    chk(expq.size() == 0, "R2 second cell", expq.size(), 0);
    chk(done[0] == 1, "R4 done set", done, 1);
    chk(chan_en[0] == 0, "R4 enable cleared", chan_en, 0);
    // R5 sticky, clear starts nothing
    settle(10);
    chk(done[0] == 1, "R5 done sticky", done, 1);
    cfg(0, 6, 0); settle(20);
    chk(done[0] == 0, "R5 done cleared", done, 0);
    chk(expq.size() == 0 && !busy, "R5 no restart", busy, 0);

    // R3 wrap with unequal sizes, cell truncated; R4 auto-enable
    do_reset();
    setup(0, 8'h30, 8'h84, 3, 2, 4);
    cfg(0, 0, ctrl(1, 0, 0, 0, 1, 0, 0));
    m_cell(0); pulse(4'b0001); settle(20);
    chk(expq.size() == 0, "R3 truncated cell", expq.size(), 0);
    chk(done[0] == 1, "R3 block done", done, 1);
    chk(chan_en[0] == 1, "R4 auto-enable kept", chan_en, 1);
    m_cell(0); pulse(4'b0001); settle(20);
    chk(expq.size() == 0, "R3 pointers back at 0", expq.size(), 0);

    // R6 R7 shared trigger, priority and tie-break
    do_reset();
    for (int c = 0; c < 4; c++) setup(c, 8 * c, 8'h80 + 8 * c, 2, 2, 1);
    cfg(0, 0, ctrl(1, 0, 0, 0, 0, 2, 1));
    cfg(1, 0, ctrl(1, 0, 0, 0, 0, 1, 1));
    cfg(2, 0, ctrl(1, 0, 0, 0, 0, 3, 1));
    cfg(3, 0, ctrl(1, 0, 0, 0, 0, 2, 1));
    m_cell(2); m_cell(0); m_cell(3); m_cell(1);
    pulse(4'b0010); settle(30);
    chk(expq.size() == 0, "R7 service order", expq.size(), 0);
    chk(done == 0, "R6 each served one cell", done, 0);

    // R8 drop when disabled without hold
    do_reset();
    setup(3, 8'h40, 8'hB0, 2, 2, 2);
    cfg(3, 0, ctrl(0, 0, 0, 0, 0, 0, 3));
    pulse(4'b1000); settle(5);
    cfg(3, 0, ctrl(1, 0, 0, 0, 0, 0, 3)); settle(20);
    chk(done[3] == 0 && !busy, "R8 dropped event", done, 0);
    // R8 hold while disabled
    cfg(3, 0, ctrl(0, 0, 0, 1, 0, 0, 3));
    pulse(4'b1000); settle(10);
    chk(done[3] == 0, "R8 held not served while disabled", done, 0);
    m_cell(3);
    cfg(3, 0, ctrl(1, 0, 0, 1, 0, 0, 3)); settle(20);
    chk(expq.size() == 0 && done[3] == 1, "R8 held served on enable", done, 8);

    // R9 chain, partner lower (dir 0)
    do_reset();
    setup(0, 8'h00, 8'h80, 2, 2, 2);
    setup(1, 8'h10, 8'h90, 2, 2, 2);
    cfg(0, 0, ctrl(1, 0, 0, 0, 0, 0, 0));
    cfg(1, 0, ctrl(0, 1, 0, 1, 0, 0, 0));
    m_cell(0); m_cell(1);
    pulse(4'b0001); settle(30);
    chk(expq.size() == 0, "R9 lower partner hand-over", expq.size(), 0);
    chk(done == 4'b0011, "R9 both done", done, 3);
    // R9 chain, partner higher (dir 1)
    do_reset();
    setup(2, 8'h20, 8'hA0, 2, 2, 2);
    setup(3, 8'h30, 8'hB0, 2, 2, 2);
    cfg(3, 0, ctrl(1, 0, 0, 0, 0, 0, 2));
    cfg(2, 0, ctrl(0, 1, 1, 1, 1, 0, 2));
    m_cell(3); m_cell(2);
    pulse(4'b0100); settle(30);
    chk(expq.size() == 0, "R9 higher partner hand-over", expq.size(), 0);
    chk(chan_en == 4'b0100, "R9 partner enable", chan_en, 4);

    // R10 merge of repeated triggers while pending
    do_reset();
    setup(0, 8'h00, 8'h80, 4, 4, 4);
    setup(1, 8'h10, 8'hA0, 4, 4, 1);
    cfg(0, 0, ctrl(1, 0, 0, 0, 0, 3, 0));
    cfg(1, 0, ctrl(1, 0, 0, 0, 0, 0, 1));
    m_cell(0); m_cell(1);
    pulse(4'b0001); pulse(4'b0010); pulse(4'b0010); settle(30);
    chk(expq.size() == 0, "R10 one cell for merged events", expq.size(), 0);
    chk(done == 4'b0001, "R10 done flags", done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule